// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservation table that backs load-linked and store-conditional pairs issued by several requesting contexts. Each context may own one reservation on an address granule. A load-linked request records or moves that reservation. A store-conditional is granted only while the issuing context still holds a reservation on the same granule. Any store that is allowed to write, plain or conditional, wipes out every reservation on the granule it touches, no matter which context owns it.

One request is accepted in each cycle. The block answers with a registered write-permit flag, a conditional-success bit and a wakeup pulse vector, one bit per context. A wakeup bit pulses for each context whose reservation was removed by a write, so that a context waiting on the lock can resume. Memory storage and data movement stay outside the block; it only decides whether a write may go ahead.

Top module: `resv_monitor`

## Requirements
- R1: After reset, or after a reset asserted at any time, no context holds a reservation and `st_allow`, `sc_ok` and `wake` are all zero.
- R2: A load-linked (`req_op` = 2'b00) records a reservation for `req_ctx`. A following store-conditional (`req_op` = 2'b10) from the same context to the same granule returns `sc_ok` = 1 and `st_allow` = 1.
- R3: Each context holds one reservation at most. A second load-linked from that context moves the reservation to the new granule, and a store-conditional to the old granule then fails.
- R4: Addresses are compared per granule of 2^GRAN_LG bytes (64 by default). Addresses that differ only in bits [GRAN_LG-1:0] match.
- R5: A store-conditional fails (`sc_ok` = 0, `st_allow` = 0) when the issuing context has no reservation on the request granule. This includes the cases where only other contexts hold that granule, and where the issuing context has a reservation on a different granule.
- R6: A plain store (`req_op` = 2'b01) always gets `st_allow` = 1 and `sc_ok` = 0, whatever the table holds.
- R7: A successful store-conditional or a plain store removes every reservation on the written granule, across all contexts. Reservations on other granules are kept.
- R8: A failed store-conditional changes no reservation, including the reservations held by other contexts and the issuer's own reservation elsewhere.
- R9: Each reservation removed by a write drives its context's bit of `wake` high for exactly one cycle, in the same cycle as the `st_allow` answer.
- R10: Outputs are registered and appear in the cycle after the request. With `req_vld` low, or with `req_op` = 2'b11, all outputs are zero and the table is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| req_ctx | input | CTX_W | Issuing context |
| req_addr | input | ADDR_W | Physical byte address |
| req_op | input | 2 | 00 load-linked, 01 store, 10 store-conditional, 11 none |
| st_allow | output | 1 | Write may proceed (registered) |
| sc_ok | output | 1 | Store-conditional result, 1 = success (registered) |
| wake | output | CTX_N | Per-context wakeup pulse for cleared reservations |

## Verification
The hardest case to reach from the ports is several contexts sharing one granule while a third context holds an unrelated reservation. A single write must then clear exactly the sharers and leave the bystander intact. The stimulus builds that table with separate load-linked requests using unaligned offsets inside the granule. It then sends failed store-conditionals that must leave the table alone, and proves this by a later success. The store that clears the sharers must show a multi-bit `wake` pattern, and the surviving reservation is checked by a final successful conditional.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LL   = 2'b00,
    OP_ST   = 2'b01,
    OP_SC   = 2'b10,
    OP_NONE = 2'b11
  } resv_op_e;
endpackage

// File: rtl/resv_entry.sv
module resv_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] set_addr,
  output logic              vld,
  output logic [ADDR_W-1:0] addr
);
  logic vld_nxt;
  logic addr_en;

  always_comb begin
    vld_nxt = vld;
    if (set_en)      vld_nxt = 1'b1;
    else if (clr_en) vld_nxt = 1'b0;
    addr_en = set_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      addr <= '0;
    end else begin
      vld <= vld_nxt;
      if (addr_en) addr <= set_addr;
    end
  end

  // R2: a recorded reservation holds the requested granule
  p_set_records_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (vld && addr == $past(set_addr)));
  // R7: a clear request drops the entry
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !vld);
endmodule

// File: rtl/resv_decide.sv
module resv_decide
  import resv_pkg::*;
#(
  parameter int CTX_N  = 4,
  parameter int ADDR_W = 32,
  parameter int CTX_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_vld,
  input  resv_op_e                     req_op,
  input  logic [CTX_W-1:0]             req_ctx,
  input  logic [ADDR_W-1:0]            req_gaddr,
  input  logic [CTX_N-1:0]             ent_vld,
  input  logic [CTX_N-1:0][ADDR_W-1:0] ent_addr,
  output logic [CTX_N-1:0]             set_vec,
  output logic [CTX_N-1:0]             clr_vec,
  output logic                         allow,
  output logic                         sc_ok
);
  logic [CTX_N-1:0] hit;
  logic             own_hit;
  logic             is_ll, is_st, is_sc;

  always_comb begin
    is_ll   = req_vld && (req_op == OP_LL);
    is_st   = req_vld && (req_op == OP_ST);
    is_sc   = req_vld && (req_op == OP_SC);
    own_hit = 1'b0;
    set_vec = '0;
    for (int i = 0; i < CTX_N; i++) begin
      hit[i] = ent_vld[i] && (ent_addr[i] == req_gaddr);
      if (req_ctx == CTX_W'(i)) begin
        own_hit    = hit[i];
        set_vec[i] = is_ll;
      end
    end
    sc_ok   = is_sc && own_hit;
    allow   = is_st || sc_ok;
    clr_vec = allow ? hit : '0;
  end

  // R3: a load-linked touches at most one entry
  p_one_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
  // R5: a conditional without any live entry on the granule cannot pass
  p_sc_needs_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && ((ent_vld & hit) == '0)) |-> !sc_ok);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int CTX_N   = 4,
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 6,
  localparam int CTX_W  = (CTX_N > 1) ? $clog2(CTX_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [CTX_W-1:0]  req_ctx,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  output logic              st_allow,
  output logic              sc_ok,
  output logic [CTX_N-1:0]  wake
);
  localparam int GRAN_W = ADDR_W - GRAN_LG;
  localparam logic [ADDR_W-1:0] GMASK = {{GRAN_W{1'b1}}, {GRAN_LG{1'b0}}};

  resv_op_e                     op;
  logic [ADDR_W-1:0]            req_gaddr;
  logic [CTX_N-1:0]             ent_vld;
  logic [CTX_N-1:0][ADDR_W-1:0] ent_addr;
  logic [CTX_N-1:0]             set_vec, clr_vec;
  logic                         allow_d, ok_d;
  logic                         allow_nxt, ok_nxt;
  logic [CTX_N-1:0]             wake_nxt;

  assign op        = resv_op_e'(req_op);
  assign req_gaddr = req_addr & GMASK;

  resv_decide #(.CTX_N(CTX_N), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_op   (op),
    .req_ctx  (req_ctx),
    .req_gaddr(req_gaddr),
    .ent_vld  (ent_vld),
    .ent_addr (ent_addr),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .allow    (allow_d),
    .sc_ok    (ok_d)
  );

  for (genvar g = 0; g < CTX_N; g++) begin : g_ent
    resv_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (set_vec[g]),
      .clr_en  (clr_vec[g]),
      .set_addr(req_gaddr),
      .vld     (ent_vld[g]),
      .addr    (ent_addr[g])
    );
  end

  always_comb begin
    allow_nxt = allow_d;
    ok_nxt    = ok_d;
    wake_nxt  = clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_allow <= 1'b0;
      sc_ok    <= 1'b0;
      wake     <= '0;
    end else begin
      st_allow <= allow_nxt;
      sc_ok    <= ok_nxt;
      wake     <= wake_nxt;
    end
  end

  // R2: conditional success always carries write permission
  p_ok_allows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |-> st_allow);
  // R6: plain stores are always permitted and never report conditional success
  p_store_allowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && op == OP_ST) |=> (st_allow && !sc_ok));
  // R8: a failing conditional leaves the table alone
  p_fail_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && op == OP_SC && !ok_d) |=> ($stable(ent_vld) && wake == '0));
  // R9: wakeups only accompany a permitted write
  p_wake_with_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake != '0) |-> st_allow);
  // R10: no request, no answer
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_vld || op == OP_NONE) |=> (!st_allow && !sc_ok && wake == '0));
endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
  localparam int CTX_N = 4;
  localparam int ADDR_W = 32;
  localparam int NV = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_vld = 1'b0;
  logic [1:0]        req_ctx = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_op = 2'b11;
  logic              st_allow, sc_ok;
  logic [CTX_N-1:0]  wake;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  resv_monitor #(.CTX_N(CTX_N), .ADDR_W(ADDR_W), .GRAN_LG(6)) i_resv_monitor (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_ctx(req_ctx),
    .req_addr(req_addr), .req_op(req_op),
    .st_allow(st_allow), .sc_ok(sc_ok), .wake(wake));

  // {op, ctx, addr, exp_allow, exp_ok, exp_wake}
  localparam logic [41:0] VEC [NV] = '{
    {2'b00, 2'd0, 32'h0000_0100, 1'b0, 1'b0, 4'b0000}, // R2 LL c0
    {2'b10, 2'd0, 32'h0000_013C, 1'b1, 1'b1, 4'b0001}, // R2 R4 SC same granule
    {2'b10, 2'd0, 32'h0000_0100, 1'b0, 1'b0, 4'b0000}, // R5 entry gone
    {2'b00, 2'd1, 32'h0000_0200, 1'b0, 1'b0, 4'b0000},
    {2'b00, 2'd2, 32'h0000_0211, 1'b0, 1'b0, 4'b0000},
    {2'b00, 2'd3, 32'h0000_0300, 1'b0, 1'b0, 4'b0000},
    {2'b10, 2'd0, 32'h0000_0200, 1'b0, 1'b0, 4'b0000}, // R5 other ctx only
    {2'b10, 2'd3, 32'h0000_0200, 1'b0, 1'b0, 4'b0000}, // R5 R8 own entry elsewhere
    {2'b01, 2'd0, 32'h0000_023F, 1'b1, 1'b0, 4'b0110}, // R6 R7 R9 clears sharers
    {2'b10, 2'd1, 32'h0000_0200, 1'b0, 1'b0, 4'b0000}, // R7 c1 cleared
    {2'b10, 2'd3, 32'h0000_0300, 1'b1, 1'b1, 4'b1000}, // R7 R8 c3 kept
    {2'b00, 2'd1, 32'h0000_0400, 1'b0, 1'b0, 4'b0000},
    {2'b00, 2'd1, 32'h0000_0500, 1'b0, 1'b0, 4'b0000}, // R3 move
    {2'b10, 2'd1, 32'h0000_0400, 1'b0, 1'b0, 4'b0000}, // R3 old granule fails
    {2'b10, 2'd1, 32'h0000_0520, 1'b1, 1'b1, 4'b0010}, // R3 new granule passes
    {2'b01, 2'd2, 32'h0000_0700, 1'b1, 1'b0, 4'b0000}, // R6 empty table
    {2'b11, 2'd0, 32'h0000_0700, 1'b0, 1'b0, 4'b0000}  // R10 no-op code
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [1:0] op, input logic [1:0] ctx, input logic [31:0] a);
    req_vld = 1'b1; req_op = op; req_ctx = ctx; req_addr = a;
    @(negedge clk);
    req_vld = 1'b0; req_op = 2'b11;
  endtask

  task automatic chk_out(input string tag, input logic al, input logic ok, input logic [3:0] wk);
    chk({tag, " st_allow"}, 32'(st_allow), 32'(al));
    chk({tag, " sc_ok"}, 32'(sc_ok), 32'(ok));
    chk({tag, " wake"}, 32'(wake), 32'(wk));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_out("R1 reset", 1'b0, 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    req(2'b10, 2'd0, 32'h0);
    chk_out("R1 empty after reset", 1'b0, 1'b0, 4'b0000);

    for (int v = 0; v < NV; v++) begin
      req(VEC[v][41:40], VEC[v][39:38], VEC[v][37:6]);
      chk_out($sformatf("vec%0d", v), VEC[v][5], VEC[v][4], VEC[v][3:0]);
    end

    // R9: wake lasts one cycle
    req(2'b00, 2'd2, 32'h0000_0900);
    req(2'b01, 2'd0, 32'h0000_0900);
    chk_out("R9 pulse", 1'b1, 1'b0, 4'b0100);
    @(negedge clk);
    chk_out("R9 pulse ends R10 idle", 1'b0, 1'b0, 4'b0000);

    // R10: invalid request and no-op code leave the table alone
    req(2'b00, 2'd0, 32'h0000_0800);
    req_vld = 1'b0; req_op = 2'b01; req_ctx = 2'd1; req_addr = 32'h0000_0800;
    @(negedge clk);
    chk_out("R10 vld low", 1'b0, 1'b0, 4'b0000);
    req(2'b11, 2'd0, 32'h0000_0800);
    chk_out("R10 op none", 1'b0, 1'b0, 4'b0000);
    req(2'b10, 2'd0, 32'h0000_0800);
    chk_out("R10 table kept", 1'b1, 1'b1, 4'b0001);

    // R1: reset mid-run drops reservations
    req(2'b00, 2'd3, 32'h0000_0A00);
    rst_n = 1'b0;
    @(negedge clk);
    chk_out("R1 reset mid-run", 1'b0, 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    req(2'b10, 2'd3, 32'h0000_0A00);
    chk_out("R1 entry dropped", 1'b0, 1'b0, 4'b0000);

    done = 1'b1;
    finish_run();
  end
endmodule